// File: doc/BRIEF.md
# Pulse-Width Serial Frame Encoder

This block sends a 26-bit data word over a single output wire as a frame of fixed-length time slots. Timing comes from one base tick per slot, produced from the system clock by a divider set with `CLKS_PER_SLOT`. The default of 2000 clocks per slot gives a 10 µs slot at 200 MHz. Between frames the wire rests low. A frame opens with one high slot. Every data bit then takes a three-slot cell that starts low and ends high, and the ratio of low to high in the cell gives the bit's value.

The host offers a word with a one-cycle load strobe while `ready_o` is high. The block takes the word into an internal shift register, drops `ready_o`, and raises `busy_o` for the length of the frame. After the last bit it also holds a guaranteed low gap before it accepts the next word. A strobe that arrives while the block is busy has no effect. The gap is always longer than three slots, so a receiver can always find the start of the next frame.

Top module: `slot_frame_encoder`

## Requirements
- R1: While `rst` is high, `line_o` is 0, `ready_o` is 0 and `busy_o` is 1. Reset may be asserted in the middle of a frame. After `rst` is released, `ready_o` rises exactly `GAP_SLOTS*CLKS_PER_SLOT` cycles later, measured from the first rising edge that samples `rst` low.
- R2: A word is accepted when `load_i` is high at a rising edge while `ready_o` is high. At that same edge `ready_o` falls, `busy_o` rises and `line_o` goes to 1. `line_o` then stays at 1 for exactly one slot (`CLKS_PER_SLOT` cycles).
- R3: Each data bit is a cell of 3 slots, low first. A 0 is 1 slot low followed by 2 slots high. A 1 is 2 slots low followed by 1 slot high. No high run on `line_o` is ever longer than 2 slots.
- R4: A frame carries exactly `DATA_W` (26) bits, most-significant first: `data_i[25]` is in the first cell and `data_i[0]` is in the last.
- R5: After the last cell `line_o` returns to 0. `ready_o` rises after exactly `GAP_SLOTS` slots (default 4). Every low run that ends with `ready_o` rising is therefore longer than 3 slots.
- R6: `load_i` is ignored whenever `ready_o` is low, both during a frame and during the idle gap after it. The frame in progress keeps its word and timing, and no new frame starts once the gap ends.
- R7: While `ready_o` is high, `line_o` is 0 and `busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Load strobe, taken only while ready_o is high |
| data_i | input | DATA_W | Word to send, MSB first |
| ready_o | output | 1 | High when a new word can be accepted |
| busy_o | output | 1 | High while a frame or its idle gap is in progress |
| line_o | output | 1 | Serial output wire |

## Verification
The bound checker checks on every cycle the properties that hold cycle by cycle:
- the line stays low while the block is ready;
- an accepted strobe raises the line in the same cycle;
- no high run exceeds two slots;
- every low run that ends with ready rising lasts longer than three slots.

Other properties hold only over a whole frame, so only the bench's scenarios can show them. These are the exact length of each slot, the decoding of each cell into a bit, the MSB-first order, the exact reset and gap lengths, and the fact that strobes during a frame or its gap change nothing. The bench measures every run on the line in cycles and decodes the frame back to a word.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    typedef enum logic [1:0] {
        ST_GAP   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_START = 2'd2,
        ST_BITS  = 2'd3
    } sfe_state_e;

    // Line level inside a three-slot bit cell: slot 0 low, slot 1 carries the
    // inverted bit value, slot 2 high.
    function automatic logic cell_level(input logic bit_v, input logic [1:0] slot);
        logic lvl;
        case (slot)
            2'd0:    lvl = 1'b0;
            2'd1:    lvl = ~bit_v;
            default: lvl = 1'b1;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/sfe_tick_gen.sv
module sfe_tick_gen #(
    parameter int CLKS_PER_SLOT = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int CNT_W = (CLKS_PER_SLOT > 1) ? $clog2(CLKS_PER_SLOT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLKS_PER_SLOT - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == CNT_LAST);

    always_comb begin
        if (restart || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/sfe_shift_reg.sv
module sfe_shift_reg #(
    parameter int DATA_W = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic              shift_en,
    input  logic [DATA_W-1:0] data_i,
    output logic              msb_o
);
    logic [DATA_W-1:0] sh_d, sh_q;

    assign msb_o = sh_q[DATA_W-1];

    always_comb begin
        if (load_en) begin
            sh_d = data_i;
        end else if (shift_en) begin
            sh_d = {sh_q[DATA_W-2:0], 1'b0};
        end else begin
            sh_d = sh_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end
endmodule

// File: rtl/slot_frame_encoder.sv
module slot_frame_encoder #(
    parameter int CLKS_PER_SLOT = 2000,
    parameter int DATA_W        = 26,
    parameter int GAP_SLOTS     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              ready_o,
    output logic              busy_o,
    output logic              line_o
);
    import sfe_pkg::*;

    localparam int GAP_W = (GAP_SLOTS > 1) ? $clog2(GAP_SLOTS) : 1;
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_SLOTS - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    typedef struct packed {
        sfe_state_e       state;
        logic [GAP_W-1:0] gap;
        logic [IDX_W-1:0] idx;
        logic [1:0]       slot;
        logic             line;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{state: ST_GAP, gap: '0, idx: '0, slot: '0, line: 1'b0};

    ctl_t ctl_d, ctl_q;
    logic tick;
    logic accept;
    logic shift_en;
    logic cur_bit;

    assign accept   = (ctl_q.state == ST_IDLE) && load_i;
    assign shift_en = tick && (ctl_q.state == ST_BITS) && (ctl_q.slot == 2'd2)
                      && (ctl_q.idx != IDX_LAST);

    // Slot divider, realigned at each accepted word so the start slot is full length.
    sfe_tick_gen #(
        .CLKS_PER_SLOT(CLKS_PER_SLOT)
    ) u_tick (
        .clk     (clk),
        .rst     (rst),
        .restart (accept),
        .tick    (tick)
    );

    sfe_shift_reg #(
        .DATA_W(DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load_en  (accept),
        .shift_en (shift_en),
        .data_i   (data_i),
        .msb_o    (cur_bit)
    );

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.state)
            ST_GAP: begin
                ctl_d.line = 1'b0;
                if (tick) begin
                    if (ctl_q.gap == GAP_LAST) begin
                        ctl_d.state = ST_IDLE;
                        ctl_d.gap   = '0;
                    end else begin
                        ctl_d.gap = ctl_q.gap + GAP_W'(1);
                    end
                end
            end
            ST_IDLE: begin
                ctl_d.line = 1'b0;
                if (load_i) begin
                    ctl_d.state = ST_START;
                    ctl_d.line  = 1'b1;
                end
            end
            ST_START: begin
                if (tick) begin
                    ctl_d.state = ST_BITS;
                    ctl_d.idx   = '0;
                    ctl_d.slot  = 2'd0;
                    ctl_d.line  = cell_level(cur_bit, 2'd0);
                end
            end
            default: begin
                if (tick) begin
                    if (ctl_q.slot == 2'd2) begin
                        ctl_d.slot = 2'd0;
                        ctl_d.line = 1'b0;
                        if (ctl_q.idx == IDX_LAST) begin
                            ctl_d.state = ST_GAP;
                            ctl_d.gap   = '0;
                            ctl_d.idx   = '0;
                        end else begin
                            ctl_d.idx = ctl_q.idx + IDX_W'(1);
                        end
                    end else begin
                        ctl_d.slot = ctl_q.slot + 2'd1;
                        ctl_d.line = cell_level(cur_bit, ctl_q.slot + 2'd1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= CTL_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ready_o = (ctl_q.state == ST_IDLE);
    assign busy_o  = (ctl_q.state != ST_IDLE);
    assign line_o  = ctl_q.line;
endmodule

// File: rtl/sfe_checker.sv
module sfe_checker #(
    parameter int CLKS_PER_SLOT = 2000,
    parameter int GAP_SLOTS     = 4
) (
    input logic clk,
    input logic rst,
    input logic load_i,
    input logic ready_o,
    input logic busy_o,
    input logic line_o
);
    logic [31:0] low_run_q, high_run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run_q  <= '0;
            high_run_q <= '0;
        end else begin
            low_run_q  <= line_o ? 32'd0 : low_run_q + 32'd1;
            high_run_q <= line_o ? high_run_q + 32'd1 : 32'd0;
        end
    end

    // R7: the line rests low whenever a new word may be taken
    p_idle_low_r7: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> !line_o);

    // R2: busy only begins from ready with a strobe, and the start pulse is up at once
    p_accept_start_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> ($past(ready_o) && $past(load_i) && line_o));

    // R3: no high run reaches past two slots
    p_high_run_r3: assert property (@(posedge clk) disable iff (rst)
        line_o |-> (high_run_q < 32'(2 * CLKS_PER_SLOT)));

    // R5: readiness only returns after a low run longer than three slots
    p_gap_len_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> (low_run_q > 32'((GAP_SLOTS - 1) * CLKS_PER_SLOT)));
endmodule

bind slot_frame_encoder sfe_checker #(
    .CLKS_PER_SLOT(CLKS_PER_SLOT),
    .GAP_SLOTS    (GAP_SLOTS)
) i_sfe_checker (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_i),
    .ready_o (ready_o),
    .busy_o  (busy_o),
    .line_o  (line_o)
);

// File: tb/test_slot_frame_encoder.sv
`timescale 1ns/1ps
module test_slot_frame_encoder;
    localparam int N    = 4;
    localparam int W    = 26;
    localparam int GAPS = 4;
    localparam int NVEC = 6;

    // {word, expected total low slots inside the cells}
    localparam logic [57:0] VECS [NVEC] = '{
        {26'h0000000, 32'd26},
        {26'h3FFFFFF, 32'd52},
        {26'h2AAAAAA, 32'd39},
        {26'h1555555, 32'd39},
        {26'h2000001, 32'd28},
        {26'h3FFFFFE, 32'd51}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic load = 1'b0;
    logic [W-1:0] data_in = '0;
    logic ready, busy, line;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int inject_at = -1;
    logic [W-1:0] inject_word = '0;
    bit done = 0;

    logic [W-1:0] got_word;
    int low_slots, start_len, gap_len;
    bit timing_ok, gap_low_ok;

    always #2.5 clk = ~clk;

    slot_frame_encoder #(
        .CLKS_PER_SLOT(N),
        .DATA_W       (W),
        .GAP_SLOTS    (GAPS)
    ) i_slot_frame_encoder (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .data_i  (data_in),
        .ready_o (ready),
        .busy_o  (busy),
        .line_o  (line)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        if (cyc == inject_at) begin
            load    = 1'b1;
            data_in = inject_word;
        end else begin
            load = 1'b0;
        end
    endtask

    task automatic run_frame(input logic [W-1:0] w);
        int lo, hi;
        while (!ready) @(negedge clk);
        check(!line && !busy, "R7", "line/busy while ready", {line, busy}, 0);
        data_in = w;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        cyc = 0;
        start_len = 0;
        while (line) begin start_len++; step(); end
        timing_ok = 1;
        low_slots = 0;
        got_word  = '0;
        for (int i = 0; i < W; i++) begin
            lo = 0;
            while (!line) begin lo++; step(); end
            hi = 0;
            while (line) begin hi++; step(); end
            if (lo == 2*N && hi == N)      got_word = {got_word[W-2:0], 1'b1};
            else if (lo == N && hi == 2*N) got_word = {got_word[W-2:0], 1'b0};
            else timing_ok = 0;
            low_slots += lo / N;
        end
        gap_len = 0;
        gap_low_ok = 1;
        while (!ready) begin
            if (line) gap_low_ok = 0;
            gap_len++;
            step();
        end
        load = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int r;
        logic [W-1:0] w;
        // R1: reset state and first readiness
        repeat (3) @(negedge clk);
        check(!line && !ready && busy, "R1", "outputs in reset", {line, ready, busy}, 3'b001);
        rst = 1'b0;
        r = 0;
        while (!ready) begin @(negedge clk); r++; end
        check(r == GAPS*N, "R1", "cycles to ready after reset", r, GAPS*N);

        // Table of vectors: R2 start, R3 cells, R4 order, R5 gap
        for (int v = 0; v < NVEC; v++) begin
            w = VECS[v][57:32];
            inject_at = -1;
            run_frame(w);
            check(start_len == N, "R2", "start pulse cycles", start_len, N);
            check(timing_ok, "R3", "cell timing", timing_ok, 1);
            check(got_word == w, "R4", "decoded word", got_word, w);
            check(low_slots == int'(VECS[v][31:0]), "R3", "low slots in cells",
                  low_slots, VECS[v][31:0]);
            check(gap_len == GAPS*N && gap_low_ok, "R5", "gap cycles", gap_len, GAPS*N);
        end

        // R6: strobe in the middle of a frame is ignored
        w = 26'h0ABCDEF;
        inject_word = ~w;
        inject_at = 10*N + 1;
        run_frame(w);
        check(got_word == w && timing_ok, "R6", "word with mid-frame strobe", got_word, w);
        check(gap_len == GAPS*N, "R6", "gap with mid-frame strobe", gap_len, GAPS*N);

        // R6: strobe in the idle gap is ignored, no new frame follows
        w = 26'h1234567;
        inject_word = 26'h3FFFFFF;
        inject_at = 79*N + 2;
        run_frame(w);
        inject_at = -1;
        check(got_word == w && gap_len == GAPS*N, "R6", "word with gap strobe", got_word, w);
        r = 0;
        for (int k = 0; k < 3*N; k++) begin
            @(negedge clk);
            if (!ready || line) r++;
        end
        check(r == 0, "R6", "idle cycles after gap strobe", r, 0);

        // R1: reset in the middle of a frame
        data_in = 26'h2AAAAAA;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        repeat (20*N) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!line && !ready && busy, "R1", "outputs after mid-frame reset", {line, ready, busy}, 3'b001);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        r = 0;
        while (!ready) begin
            @(negedge clk);
            r++;
        end
        check(r == GAPS*N, "R1", "cycles to ready after mid-frame reset", r, GAPS*N);
        check(!line, "R7", "line low when ready after reset", line, 0);

        // Recovery frame after reset
        w = 26'h2C3A5F0;
        run_frame(w);
        check(got_word == w && timing_ok && start_len == N, "R4", "word after reset", got_word, w);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule